// File: doc/BRIEF.md
# 16-bit Effective Address Generator

This block turns a 16-bit addressing form into a memory address. It takes the mod and r/m fields of the ModRM byte, a displacement, the four address-capable general registers and the base and limit of the data and stack segments. From these it builds the 16-bit offset within the segment and the linear address. It picks the segment from an override code or, when there is none, from the register that leads the address expression. It then compares the offset with that segment's limit. In virtual-8086 mode it folds the linear address to 20 bits.

A request strobe starts one computation. One clock later, the registered results appear together with a single-cycle valid pulse. If the offset is past the limit, a single-cycle fault pulse appears in place of the valid pulse. When mod is 3, the operand is a register rather than memory. The block flags this case and reports the chosen register's value as the offset. The reg field of ModRM (bits 5:3) plays no part.

Top module: `ea16_agu`

## Requirements
- R1: For mod 0, 1 and 2, r/m (ModRM bits 2:0) selects the registers summed into the offset as follows: 0 gives BX+SI, 1 gives BX+DI, 2 gives BP+SI, 3 gives BP+DI, 4 gives SI, 5 gives DI, 6 gives BP and 7 gives BX. The one exception is the direct form in R2.
- R2: When mod (ModRM bits 7:6) is 0 and r/m is 6, no register is used. The offset is the full 16-bit displacement, and the default segment is the data segment.
- R3: Displacement handling depends on mod. With mod 1, displacement bits 7:0 are sign-extended to 16 bits. With mod 2, all 16 displacement bits are added. With mod 0, nothing is added, apart from the direct form.
- R4: The offset is the sum of the selected registers and the displacement, taken modulo 2^16.
- R5: When mod is 3, reg_op_o is 1 and no displacement is added. The offset is the register named by r/m: 3 gives BX, 5 gives BP, 6 gives SI and 7 gives DI. Codes 0, 1, 2 and 4 give 0.
- R6: With no override, the segment is the stack segment (seg_o=1) when BP leads the expression. This covers r/m 2 and 3, r/m 6 with mod 1 or 2, and r/m 5 with mod 3. In every other case the segment is the data segment (seg_o=0).
- R7: Override code 01 forces the data segment and code 10 forces the stack segment, in both cases ahead of R6. Codes 00 and 11 leave the default in place.
- R8: If the offset, zero-extended, is greater than the chosen segment's limit, fault_o pulses and valid_o stays low. An offset equal to the limit is valid.
- R9: lin_o is the chosen segment's base plus the offset, taken modulo 2^ADDR_W. When v86_i is 1, it is masked to the low 20 bits.
- R10: Results and the valid or fault pulse appear on the first clock edge after the edge at which req_i is sampled high. Each pulse lasts one cycle. Without a request, valid_o and fault_o stay low and the other outputs hold their values.
- R11: The asynchronous active-low reset clears valid_o, fault_o and reg_op_o, and also clears the data outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| modrm_i | input | 8 | ModRM byte |
| disp_i | input | 16 | Displacement (bits 7:0 used for an 8-bit displacement) |
| bx_i | input | 16 | BX value |
| bp_i | input | 16 | BP value |
| si_i | input | 16 | SI value |
| di_i | input | 16 | DI value |
| seg_ovr_i | input | 2 | Segment override: 00 none, 01 data, 10 stack, 11 none |
| ds_base_i | input | ADDR_W | Data segment base |
| ds_limit_i | input | ADDR_W | Data segment limit |
| ss_base_i | input | ADDR_W | Stack segment base |
| ss_limit_i | input | ADDR_W | Stack segment limit |
| v86_i | input | 1 | Virtual-8086 mode |
| valid_o | output | 1 | Address valid pulse |
| fault_o | output | 1 | Limit fault pulse |
| reg_op_o | output | 1 | Operand is a register (mod 3) |
| seg_o | output | 1 | Selected segment: 0 data, 1 stack |
| ea_o | output | 16 | Effective address (offset) |
| lin_o | output | ADDR_W | Linear address |

## Verification
Every result is due exactly one edge after the edge that samples req_i. This includes the offset, linear address, segment, register-operand flag and the valid or fault pulse. A request cycle therefore has one expected outcome, and an idle cycle must show no pulse and held data. The bench keeps a behavioural model of these rules. The model is advanced only when an edge passes. Outputs are compared a short time after each rising edge, so each comparison sees the state produced by the inputs that were present before that edge. Reset is checked through the asynchronous path without waiting for a clock.

// File: rtl/ea16_pkg.sv
package ea16_pkg;
  typedef enum logic [2:0] {
    RS_NONE = 3'd0,
    RS_BX   = 3'd1,
    RS_BP   = 3'd2,
    RS_SI   = 3'd3,
    RS_DI   = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    DM_NONE = 2'd0,
    DM_S8   = 2'd1,
    DM_16   = 2'd2
  } disp_mode_e;

  localparam logic [1:0] OVR_DS = 2'b01;
  localparam logic [1:0] OVR_SS = 2'b10;

  localparam logic SEG_DS = 1'b0;
  localparam logic SEG_SS = 1'b1;

  typedef struct packed {
    reg_sel_e   base;
    reg_sel_e   index;
    disp_mode_e disp;
    logic       reg_op;
    logic       dflt_seg;
  } dec_t;
endpackage

// File: rtl/ea16_modrm_dec.sv
module ea16_modrm_dec
  import ea16_pkg::*;
(
  input  logic [7:0] modrm_i,
  output dec_t       dec_o
);
  logic [1:0] md;
  logic [2:0] rm;
  logic       unused_reg_f;

  assign md = modrm_i[7:6];
  assign rm = modrm_i[2:0];
  assign unused_reg_f = ^modrm_i[5:3];

  always_comb begin
    dec_o.base   = RS_NONE;
    dec_o.index  = RS_NONE;
    dec_o.disp   = DM_NONE;
    dec_o.reg_op = 1'b0;
    if (md == 2'd3) begin
      dec_o.reg_op = 1'b1;
      unique case (rm)
        3'd3:    dec_o.base = RS_BX;
        3'd5:    dec_o.base = RS_BP;
        3'd6:    dec_o.base = RS_SI;
        3'd7:    dec_o.base = RS_DI;
        default: dec_o.base = RS_NONE;
      endcase
    end else begin
      unique case (rm)
        3'd0: begin dec_o.base = RS_BX; dec_o.index = RS_SI; end
        3'd1: begin dec_o.base = RS_BX; dec_o.index = RS_DI; end
        3'd2: begin dec_o.base = RS_BP; dec_o.index = RS_SI; end
        3'd3: begin dec_o.base = RS_BP; dec_o.index = RS_DI; end
        3'd4: dec_o.base = RS_SI;
        3'd5: dec_o.base = RS_DI;
        3'd6: dec_o.base = (md == 2'd0) ? RS_NONE : RS_BP;
        default: dec_o.base = RS_BX;
      endcase
      unique case (md)
        2'd1:    dec_o.disp = DM_S8;
        2'd2:    dec_o.disp = DM_16;
        default: dec_o.disp = (rm == 3'd6) ? DM_16 : DM_NONE;
      endcase
    end
    // BP-led forms address the stack; direct form has no register -> data
    dec_o.dflt_seg = (dec_o.base == RS_BP) ? SEG_SS : SEG_DS;
  end
endmodule

// File: rtl/ea16_offset.sv
module ea16_offset
  import ea16_pkg::*;
#(
  parameter int unsigned OFS_W = 16
) (
  input  dec_t             dec_i,
  input  logic [OFS_W-1:0] disp_i,
  input  logic [OFS_W-1:0] bx_i,
  input  logic [OFS_W-1:0] bp_i,
  input  logic [OFS_W-1:0] si_i,
  input  logic [OFS_W-1:0] di_i,
  output logic [OFS_W-1:0] ea_o
);
  localparam int unsigned NOPS = 2;

  reg_sel_e         sel [NOPS];
  logic [OFS_W-1:0] val [NOPS];
  logic [OFS_W-1:0] disp_ext;

  assign sel[0] = dec_i.base;
  assign sel[1] = dec_i.index;

  for (genvar g = 0; g < NOPS; g++) begin : g_pick
    always_comb begin
      unique case (sel[g])
        RS_BX:   val[g] = bx_i;
        RS_BP:   val[g] = bp_i;
        RS_SI:   val[g] = si_i;
        RS_DI:   val[g] = di_i;
        default: val[g] = '0;
      endcase
    end
  end

  always_comb begin
    unique case (dec_i.disp)
      DM_S8:   disp_ext = {{(OFS_W-8){disp_i[7]}}, disp_i[7:0]};
      DM_16:   disp_ext = disp_i;
      default: disp_ext = '0;
    endcase
  end

  assign ea_o = val[0] + val[1] + disp_ext;
endmodule

// File: rtl/ea16_seg_chk.sv
module ea16_seg_chk
  import ea16_pkg::*;
#(
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned V86_W  = 20
) (
  input  logic              dflt_seg_i,
  input  logic [1:0]        seg_ovr_i,
  input  logic [OFS_W-1:0]  ea_i,
  input  logic [ADDR_W-1:0] ds_base_i,
  input  logic [ADDR_W-1:0] ds_limit_i,
  input  logic [ADDR_W-1:0] ss_base_i,
  input  logic [ADDR_W-1:0] ss_limit_i,
  input  logic              v86_i,
  output logic              seg_o,
  output logic              fault_o,
  output logic [ADDR_W-1:0] lin_o
);
  localparam logic [ADDR_W-1:0] V86_MASK = {{(ADDR_W-V86_W){1'b0}}, {V86_W{1'b1}}};

  logic [ADDR_W-1:0] ea_ext, base, limit, sum;

  always_comb begin
    unique case (seg_ovr_i)
      OVR_DS:  seg_o = SEG_DS;
      OVR_SS:  seg_o = SEG_SS;
      default: seg_o = dflt_seg_i;
    endcase
  end

  assign ea_ext  = {{(ADDR_W-OFS_W){1'b0}}, ea_i};
  assign base    = (seg_o == SEG_SS) ? ss_base_i  : ds_base_i;
  assign limit   = (seg_o == SEG_SS) ? ss_limit_i : ds_limit_i;
  assign fault_o = ea_ext > limit;
  assign sum     = base + ea_ext;
  assign lin_o   = v86_i ? (sum & V86_MASK) : sum;
endmodule

// File: rtl/ea16_agu.sv
module ea16_agu
  import ea16_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned V86_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [7:0]        modrm_i,
  input  logic [15:0]       disp_i,
  input  logic [15:0]       bx_i,
  input  logic [15:0]       bp_i,
  input  logic [15:0]       si_i,
  input  logic [15:0]       di_i,
  input  logic [1:0]        seg_ovr_i,
  input  logic [ADDR_W-1:0] ds_base_i,
  input  logic [ADDR_W-1:0] ds_limit_i,
  input  logic [ADDR_W-1:0] ss_base_i,
  input  logic [ADDR_W-1:0] ss_limit_i,
  input  logic              v86_i,
  output logic              valid_o,
  output logic              fault_o,
  output logic              reg_op_o,
  output logic              seg_o,
  output logic [15:0]       ea_o,
  output logic [ADDR_W-1:0] lin_o
);
  localparam int unsigned OFS_W = 16;

  dec_t              dec;
  logic [OFS_W-1:0]  ea_c;
  logic              seg_c, flt_c;
  logic [ADDR_W-1:0] lin_c;

  ea16_modrm_dec u_dec (
    .modrm_i (modrm_i),
    .dec_o   (dec)
  );

  ea16_offset #(.OFS_W(OFS_W)) u_ofs (
    .dec_i  (dec),
    .disp_i (disp_i),
    .bx_i   (bx_i),
    .bp_i   (bp_i),
    .si_i   (si_i),
    .di_i   (di_i),
    .ea_o   (ea_c)
  );

  ea16_seg_chk #(.OFS_W(OFS_W), .ADDR_W(ADDR_W), .V86_W(V86_W)) u_seg (
    .dflt_seg_i (dec.dflt_seg),
    .seg_ovr_i  (seg_ovr_i),
    .ea_i       (ea_c),
    .ds_base_i  (ds_base_i),
    .ds_limit_i (ds_limit_i),
    .ss_base_i  (ss_base_i),
    .ss_limit_i (ss_limit_i),
    .v86_i      (v86_i),
    .seg_o      (seg_c),
    .fault_o    (flt_c),
    .lin_o      (lin_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      fault_o  <= 1'b0;
      reg_op_o <= 1'b0;
      seg_o    <= SEG_DS;
      ea_o     <= '0;
      lin_o    <= '0;
    end else begin
      valid_o <= req_i & ~flt_c;
      fault_o <= req_i & flt_c;
      if (req_i) begin
        reg_op_o <= dec.reg_op;
        seg_o    <= seg_c;
        ea_o     <= ea_c;
        lin_o    <= lin_c;
      end
    end
  end
endmodule

// File: rtl/ea16_agu_chk.sv
module ea16_agu_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned V86_W  = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              v86_i,
  input logic [ADDR_W-1:0] ds_limit_i,
  input logic [ADDR_W-1:0] ss_limit_i,
  input logic              valid_o,
  input logic              fault_o,
  input logic              reg_op_o,
  input logic              seg_o,
  input logic [15:0]       ea_o,
  input logic [ADDR_W-1:0] lin_o
);
  // R8
  valid_fault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && fault_o));

  // R10
  valid_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o || fault_o) |-> $past(req_i));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i) |-> ($stable(ea_o) && $stable(lin_o) && $stable(reg_op_o) && $stable(seg_o)));

  // R8
  ds_within_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !seg_o) |-> ({{(ADDR_W-16){1'b0}}, ea_o} <= $past(ds_limit_i)));

  // R8
  ss_within_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && seg_o) |-> ({{(ADDR_W-16){1'b0}}, ea_o} <= $past(ss_limit_i)));

  // R9
  v86_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(v86_i)) |-> (lin_o >> V86_W) == '0);

  // R11
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      reset_clear_chk: assert (!valid_o && !fault_o && !reg_op_o);
    end
  end
endmodule

bind ea16_agu ea16_agu_chk #(.ADDR_W(ADDR_W), .V86_W(V86_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .v86_i      (v86_i),
  .ds_limit_i (ds_limit_i),
  .ss_limit_i (ss_limit_i),
  .valid_o    (valid_o),
  .fault_o    (fault_o),
  .reg_op_o   (reg_op_o),
  .seg_o      (seg_o),
  .ea_o       (ea_o),
  .lin_o      (lin_o)
);

// File: tb/ea16_agu_tb.sv
module ea16_agu_tb;
  localparam int unsigned AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic [7:0]    modrm_i = '0;
  logic [15:0]   disp_i = '0, bx_i = '0, bp_i = '0, si_i = '0, di_i = '0;
  logic [1:0]    seg_ovr_i = '0;
  logic [AW-1:0] ds_base_i = '0, ds_limit_i = '0, ss_base_i = '0, ss_limit_i = '0;
  logic          v86_i = 1'b0;
  logic          valid_o, fault_o, reg_op_o, seg_o;
  logic [15:0]   ea_o;
  logic [AW-1:0] lin_o;

  int n_vec = 0;
  int n_bad = 0;

  bit      e_valid, e_fault, e_rop, e_seg;
  longint  e_ea, e_lin;

  always #4 clk_i = ~clk_i;

  ea16_agu #(.ADDR_W(AW)) u_dut (.*);

  // Behavioural reference: returns outcome of a request with current inputs
  task automatic model(output bit rop, output bit seg, output bit flt,
                       output longint ea, output longint lin);
    int m = int'(modrm_i[7:6]);
    int r = int'(modrm_i[2:0]);
    longint a = 0;
    longint lim, base;
    bit ss = 0;
    rop = 0;
    if (m == 3) begin
      rop = 1;
      if (r == 3) a = bx_i;
      else if (r == 5) begin a = bp_i; ss = 1; end
      else if (r == 6) a = si_i;
      else if (r == 7) a = di_i;
    end else begin
      if (r < 4) begin
        a = ((r < 2) ? bx_i : bp_i) + ((r % 2 == 1) ? di_i : si_i);
        ss = (r >= 2);
      end else if (r == 4) a = si_i;
      else if (r == 5) a = di_i;
      else if (r == 6) begin
        if (m == 0) a = disp_i;
        else begin a = bp_i; ss = 1; end
      end else a = bx_i;
      if (m == 1) a = a + longint'($signed(disp_i[7:0]));
      if (m == 2) a = a + disp_i;
    end
    a = a & 64'hFFFF;
    if (seg_ovr_i == 2'b01) ss = 0;
    if (seg_ovr_i == 2'b10) ss = 1;
    base = ss ? ss_base_i : ds_base_i;
    lim  = ss ? ss_limit_i : ds_limit_i;
    flt  = a > lim;
    lin  = (base + a) & 64'hFFFF_FFFF;
    if (v86_i) lin = lin & 64'hF_FFFF;
    seg = ss;
    ea  = a;
  endtask

  task automatic check(string tag);
    n_vec++;
    if (valid_o !== e_valid || fault_o !== e_fault || reg_op_o !== e_rop ||
        seg_o !== e_seg || longint'(ea_o) !== e_ea || longint'(lin_o) !== e_lin) begin
      n_bad++;
      $display("FAIL %s: got v=%0b f=%0b r=%0b s=%0b ea=%h lin=%h exp v=%0b f=%0b r=%0b s=%0b ea=%h lin=%h",
               tag, valid_o, fault_o, reg_op_o, seg_o, ea_o, lin_o,
               e_valid, e_fault, e_rop, e_seg, e_ea[15:0], e_lin[31:0]);
    end
  endtask

  // one clock: model advances with the edge, compare 2 ns later
  task automatic step(bit req, string tag);
    bit rop, seg, flt;
    longint ea, lin;
    req_i = req;
    model(rop, seg, flt, ea, lin);
    @(posedge clk_i);
    #2;
    if (req) begin
      e_valid = !flt; e_fault = flt; e_rop = rop; e_seg = seg; e_ea = ea; e_lin = lin;
    end else begin
      e_valid = 0; e_fault = 0;
    end
    req_i = 1'b0;
    check(tag);
  endtask

  task automatic clear_exp();
    e_valid = 0; e_fault = 0; e_rop = 0; e_seg = 0; e_ea = 0; e_lin = 0;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got hang exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    clear_exp();
    #10;
    check("R11 reset state");
    @(negedge clk_i);
    rst_ni = 1'b1;
    bx_i = 16'h1000; bp_i = 16'h2000; si_i = 16'h0030; di_i = 16'h0004;
    ds_base_i = 32'h0001_0000; ss_base_i = 32'h0002_0000;
    ds_limit_i = 32'hFFFF; ss_limit_i = 32'hFFFF;
    disp_i = 16'h0080;
    step(0, "R10 idle");

    // R1 R3 R6: every r/m under mod 0,1,2
    for (int m = 0; m < 3; m++)
      for (int r = 0; r < 8; r++) begin
        modrm_i = {m[1:0], 3'b101, r[2:0]};
        step(1, "R1 R3 R6 table");
        step(0, "R10 pulse ends");
      end

    // R2 direct form
    modrm_i = 8'b00_000_110; disp_i = 16'hBEEF;
    step(1, "R2 direct");

    // R5 register operand
    for (int r = 0; r < 8; r++) begin
      modrm_i = {2'b11, 3'b000, r[2:0]};
      step(1, "R5 register operand");
    end

    // R7 overrides
    for (int o = 0; o < 4; o++) begin
      seg_ovr_i = o[1:0];
      modrm_i = 8'b01_000_010; step(1, "R7 override BP form");
      modrm_i = 8'b10_000_111; step(1, "R7 override BX form");
    end
    seg_ovr_i = 2'b00;

    // R4 wrap of 16-bit sum
    bx_i = 16'hFFFF; si_i = 16'h0002; modrm_i = 8'b10_000_000; disp_i = 16'hFFF0;
    step(1, "R4 offset wrap");
    modrm_i = 8'b01_000_111; disp_i = 16'h00FF; bx_i = 16'h0000;
    step(1, "R3 R4 negative disp8");

    // R8 limit boundary
    modrm_i = 8'b00_000_111; bx_i = 16'h0100; ds_limit_i = 32'h0100;
    step(1, "R8 at limit");
    ds_limit_i = 32'h00FF;
    step(1, "R8 past limit");
    step(0, "R8 fault pulse ends");
    modrm_i = 8'b00_000_110; disp_i = 16'h8000; ss_limit_i = 32'h7FFF; seg_ovr_i = 2'b10;
    step(1, "R8 stack limit");
    seg_ovr_i = 2'b00; ds_limit_i = 32'hFFFF;

    // R9 base add and v86 fold
    ds_base_i = 32'hFFFF_FFF0; modrm_i = 8'b00_000_110; disp_i = 16'h0020;
    step(1, "R9 base wrap");
    ds_base_i = 32'h000F_FFF0; v86_i = 1'b1;
    step(1, "R9 v86 20-bit");
    v86_i = 1'b0;
    step(0, "R10 hold");

    // R11 mid-run reset after a register-operand request
    modrm_i = 8'b11_000_011;
    step(1, "R5 before reset");
    rst_ni = 1'b0;
    #1;
    clear_exp();
    check("R11 async reset");
    @(negedge clk_i);
    rst_ni = 1'b1;

    // mixed patterns
    for (int i = 0; i < 400; i++) begin
      modrm_i = 8'($urandom); disp_i = 16'($urandom);
      bx_i = 16'($urandom); bp_i = 16'($urandom);
      si_i = 16'($urandom); di_i = 16'($urandom);
      seg_ovr_i = 2'($urandom);
      ds_base_i = $urandom; ss_base_i = $urandom;
      ds_limit_i = {16'h0, 16'($urandom)}; ss_limit_i = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : {16'h0, 16'($urandom)};
      v86_i = 1'($urandom);
      step(1'($urandom % 4 != 0), "R1 R6 R8 R9 mixed");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule